// File: doc/BRIEF.md
# Programmable Lookup-Table and Routing Tile

This block is a very small configurable logic fabric. It has two lookup tables. Each table has eight rows of two bits, so it computes two separate Boolean functions of the same three inputs. A programmable switch matrix sits between the two tables.

- The first table is addressed by three input pins.
- The switch matrix has four candidate inputs: the two outputs of the first table and two further pins.
- The switch matrix has two outputs. Each output picks any one of the four candidates through its own 4:1 multiplexer, which has its own 2-bit select.
- The two switch outputs and one more pin address the second table.
- The two data bits of the second table drive the tile outputs.

All table contents and both selects sit in one serial configuration chain. The chain is loaded while the load-enable input is high, and the bit leaving the chain is visible on a serial output so that the stored image can be read back. Outside loading, the path from the pins to the tile outputs is purely combinational.

Top module: `lut_route_tile`

## Requirements
- R1: An active-low reset clears every configuration bit to zero. After reset every tile output is 0 for every pin pattern, and the serial output reads back zeros.
- R2: On each rising clock edge with `cfg_load` high, `cfg_sin` enters the chain. Before the k-th such edge, `cfg_sout` shows bit k (counted from 0) of the image that was previously loaded, so shifting a new image out reads back the old one in load order.
- R3: The image is 36 bits, sent first bit first, in this order:
  - bits 0..15: first table, row r bit c at position 2r+c;
  - bits 16..17: select of switch output 0, low bit first;
  - bits 18..19: select of switch output 1, low bit first;
  - bits 20..35: second table, row r bit c at position 20+2r+c.
- R4: While `cfg_load` is low, clock edges and `cfg_sin` leave the stored configuration and the outputs unchanged.
- R5: While `cfg_load` is high, `tile_out` is 2'b00.
- R6: The first table's row address is `lut_a_pin` (bit 2 is the MSB). Its data bit c is that row's bit c.
- R7: Select value s on a switch output picks candidate s. Candidate 0 is first-table bit 0, candidate 1 is first-table bit 1, candidate 2 is `route_pin[0]`, candidate 3 is `route_pin[1]`.
- R8: The second table's row address is {`lut_b_pin`, switch output 1, switch output 0}. `tile_out[c]` is that row's bit c, so a 2-to-4 decoder can be mapped across the two columns.
- R9: With `cfg_load` low, a change on any pin reaches `tile_out` without a clock edge.
- R10: A table column filled with zeros gives a constant 0 on that bit, while the other column still computes its function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration |
| cfg_load | input | 1 | Shift enable for the configuration chain; forces the outputs low |
| cfg_sin | input | 1 | Serial configuration data in |
| cfg_sout | output | 1 | Bit currently at the exit end of the chain |
| lut_a_pin | input | 3 | Address of the first table |
| route_pin | input | 2 | Switch-matrix candidates 2 and 3 |
| lut_b_pin | input | 1 | Address MSB of the second table |
| tile_out | output | 2 | Second-table data bits |

## Verification
Loading the configuration and evaluating the logic can happen in the same cycle. The bench provokes this by keeping the logic pins busy while a new image is shifted in. During every such cycle it judges two things: that `tile_out` is held at zero, and that `cfg_sout` returns the previous image bit by bit. After each load, every pin pattern is swept. Each result is compared with a bench model that decodes the image by its bit positions.

// File: rtl/lut_tile_pkg.sv
package lut_tile_pkg;

  // Bits held by one table: one column per output, one row per address.
  function automatic int table_bits(input int addr_w, input int cols);
    return cols << addr_w;
  endfunction

  // Width of a select that can address n_in candidates.
  function automatic int select_width(input int n_in);
    return (n_in <= 1) ? 1 : $clog2(n_in);
  endfunction

  // Total chain length: two tables plus one select per switch output.
  function automatic int chain_bits(input int addr_w, input int cols,
                                    input int n_in, input int n_out);
    return 2 * table_bits(addr_w, cols) + n_out * select_width(n_in);
  endfunction

endpackage

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
  parameter int LEN = 36
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] q,
  output logic           dout
);

  // New bits enter at the top and move toward bit 0, so the first bit sent
  // ends up in position 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {din, q[LEN-1:1]};
  end

  assign dout = q[0];

  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q));

  a_r2_next_bit_out: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> dout == $past(q[1]));

  a_r2_entry_bit: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> q[LEN-1] == $past(din));

endmodule

// File: rtl/lut_table.sv
module lut_table #(
  parameter int ADDR_W = 3,
  parameter int COLS   = 2,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int BITS  = DEPTH * COLS
) (
  input  logic [BITS-1:0]   contents,
  input  logic [ADDR_W-1:0] addr,
  output logic [COLS-1:0]   data
);

  logic [COLS-1:0] rows [DEPTH];

  // Row r occupies bits r*COLS .. r*COLS+COLS-1; column c is bit c of the row.
  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    assign rows[r] = contents[r*COLS +: COLS];
  end

  assign data = rows[addr];

endmodule

// File: rtl/switch_matrix.sv
module switch_matrix #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 2,
  localparam int SEL_W = lut_tile_pkg::select_width(N_IN)
) (
  input  logic [N_OUT*SEL_W-1:0] sel,
  input  logic [N_IN-1:0]        m_in,
  output logic [N_OUT-1:0]       o_out
);

  // One multiplexer per output, each steered by its own select field.
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [SEL_W-1:0] pick;
    assign pick     = sel[k*SEL_W +: SEL_W];
    assign o_out[k] = m_in[pick];
  end

endmodule

// File: rtl/lut_route_tile.sv
module lut_route_tile #(
  parameter int LUT_IN   = 3,
  parameter int LUT_OUT  = 2,
  parameter int ROUTE_EXT = 2,
  parameter int SW_OUT   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_load,
  input  logic                      cfg_sin,
  output logic                      cfg_sout,
  input  logic [LUT_IN-1:0]         lut_a_pin,
  input  logic [ROUTE_EXT-1:0]      route_pin,
  input  logic [LUT_IN-SW_OUT-1:0]  lut_b_pin,
  output logic [LUT_OUT-1:0]        tile_out
);

  import lut_tile_pkg::*;

  localparam int SW_IN    = LUT_OUT + ROUTE_EXT;
  localparam int SEL_W    = select_width(SW_IN);
  localparam int TBL_BITS = table_bits(LUT_IN, LUT_OUT);
  localparam int SEL_BITS = SW_OUT * SEL_W;
  localparam int CHAIN    = chain_bits(LUT_IN, LUT_OUT, SW_IN, SW_OUT);
  localparam int SEL_LO   = TBL_BITS;
  localparam int TBLB_LO  = TBL_BITS + SEL_BITS;

  logic [CHAIN-1:0]    cfg_q;
  logic [TBL_BITS-1:0] tbl_a_img;
  logic [TBL_BITS-1:0] tbl_b_img;
  logic [SEL_BITS-1:0] sel_img;
  logic [LUT_OUT-1:0]  lut_a_data;
  logic [LUT_OUT-1:0]  lut_b_data;
  logic [SW_IN-1:0]    sw_in_bus;
  logic [SW_OUT-1:0]   sw_out_bus;
  logic [LUT_IN-1:0]   lut_b_addr;

  cfg_shift_chain #(.LEN(CHAIN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_load),
    .din      (cfg_sin),
    .q        (cfg_q),
    .dout     (cfg_sout)
  );

  // Chain layout: first table, then the selects, then the second table.
  assign tbl_a_img = cfg_q[TBL_BITS-1:0];
  assign sel_img   = cfg_q[SEL_LO +: SEL_BITS];
  assign tbl_b_img = cfg_q[TBLB_LO +: TBL_BITS];

  lut_table #(.ADDR_W(LUT_IN), .COLS(LUT_OUT)) u_lut_a (
    .contents (tbl_a_img),
    .addr     (lut_a_pin),
    .data     (lut_a_data)
  );

  // The first-table bits are candidates 0..LUT_OUT-1; the route pins follow.
  assign sw_in_bus = {route_pin, lut_a_data};

  switch_matrix #(.N_IN(SW_IN), .N_OUT(SW_OUT)) u_switch (
    .sel   (sel_img),
    .m_in  (sw_in_bus),
    .o_out (sw_out_bus)
  );

  // Switch output k drives address bit k; the extra pins take the top bits.
  assign lut_b_addr = {lut_b_pin, sw_out_bus};

  lut_table #(.ADDR_W(LUT_IN), .COLS(LUT_OUT)) u_lut_b (
    .contents (tbl_b_img),
    .addr     (lut_b_addr),
    .data     (lut_b_data)
  );

  assign tile_out = cfg_load ? '0 : lut_b_data;

  a_r5_quiet_while_loading: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> tile_out == '0);

  a_r7_all_low_routes_low: assert property (@(posedge clk) disable iff (!rst_n)
    sw_in_bus == '0 |-> sw_out_bus == '0);

  a_r7_all_high_routes_high: assert property (@(posedge clk) disable iff (!rst_n)
    sw_in_bus == '1 |-> sw_out_bus == '1);

  a_r10_empty_table_low: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_b_img == '0 |-> tile_out == '0);

  a_r4_config_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(sel_img) && $stable(tbl_a_img) && $stable(tbl_b_img));

endmodule

// File: tb/tb_lut_route_tile.sv
module tb_lut_route_tile;

  localparam int NB = 36;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 1'b0;
  logic       cfg_sin = 1'b0;
  logic       cfg_sout;
  logic [2:0] lut_a_pin = '0;
  logic [1:0] route_pin = '0;
  logic [0:0] lut_b_pin = '0;
  logic [1:0] tile_out;

  int checks = 0;
  int fails  = 0;
  logic [NB-1:0] cur = '0;

  always #4 clk = ~clk;

  lut_route_tile dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_sin(cfg_sin),
    .cfg_sout(cfg_sout), .lut_a_pin(lut_a_pin), .route_pin(route_pin),
    .lut_b_pin(lut_b_pin), .tile_out(tile_out)
  );

  // Reference model that reads the image by the bit positions given in R3.
  function automatic logic [1:0] model(input logic [NB-1:0] c, input logic [2:0] x,
                                       input logic [1:0] m, input logic z);
    int ra, rb, s0, s1;
    logic [3:0] cand;
    logic o0, o1;
    ra   = int'(x);
    cand = {m[1], m[0], c[2*ra+1], c[2*ra]};
    s0   = int'(c[17:16]);
    s1   = int'(c[19:18]);
    o0   = cand[s0];
    o1   = cand[s1];
    rb   = 4*int'(z) + 2*int'(o1) + int'(o0);
    return {c[20+2*rb+1], c[20+2*rb]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [NB-1:0] act,
                     input logic [NB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Shift in a new image. Before each edge, check the readback of the old
  // image (R2) and that the outputs are held low (R5), while the pins move.
  task automatic load(input logic [NB-1:0] nv);
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      cfg_load  = 1'b1;
      cfg_sin   = nv[i];
      lut_a_pin = 3'($urandom);
      route_pin = 2'($urandom);
      lut_b_pin = 1'($urandom);
      #1;
      chk(cfg_sout == cur[i], "R2 readback", NB'(cfg_sout), NB'(cur[i]));
      chk(tile_out == 2'b00, "R5 outputs low while loading", NB'(tile_out), '0);
    end
    @(negedge clk);
    cfg_load = 1'b0;
    cur = nv;
  endtask

  // Visit every pin pattern; the pins change and the result is checked with
  // no clock edge in between (R9).
  task automatic sweep(input string tag);
    for (int p = 0; p < 64; p++) begin
      logic [1:0] e;
      @(posedge clk);
      #1;
      lut_a_pin = p[2:0];
      route_pin = p[4:3];
      lut_b_pin = p[5];
      #2;
      e = model(cur, p[2:0], p[4:3], p[5]);
      chk(tile_out == e, tag, NB'(tile_out), NB'(e));
    end
  endtask

  initial begin
    #(8 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [NB-1:0] v;
    void'($urandom(32'd20240611));

    // R1: state after reset
    repeat (3) @(posedge clk);
    #1;
    chk(cfg_sout == 1'b0, "R1 sout after reset", NB'(cfg_sout), '0);
    rst_n = 1'b1;
    sweep("R1 outputs zero after reset");

    // R3: only second-table row 7 bit 1 set, both outputs routed to pins.
    // Expect tile_out[1] = lut_b_pin & route_pin[1] & route_pin[0].
    v = '0;
    v[17:16] = 2'd2;
    v[19:18] = 2'd3;
    v[35] = 1'b1;
    load(v);
    sweep("R3 R7 positional map");
    for (int p = 0; p < 8; p++) begin
      @(posedge clk);
      #1;
      {lut_b_pin, route_pin} = p[2:0];
      #2;
      chk(tile_out == {&p[2:0], 1'b0}, "R3 row 7 column 1", NB'(tile_out),
          NB'({&p[2:0], 1'b0}));
    end

    // R8: 2-to-4 decoder. The first table passes its address bits, the
    // switch routes them through, and lut_b_pin selects the decoder half.
    v = '0;
    for (int r = 0; r < 8; r++) begin
      v[2*r]   = r[0];
      v[2*r+1] = r[1];
    end
    v[17:16] = 2'd0;
    v[19:18] = 2'd1;
    for (int r = 0; r < 8; r++) begin
      v[20+2*r]   = (r[1:0] == {r[2], 1'b0});
      v[20+2*r+1] = (r[1:0] == {r[2], 1'b1});
    end
    load(v);
    sweep("R6 R8 decoder");
    for (int p = 0; p < 8; p++) begin
      logic [1:0] e;
      @(posedge clk);
      #1;
      lut_a_pin = {1'b0, p[1:0]};
      lut_b_pin = p[2];
      #2;
      e = {p[1:0] == {p[2], 1'b1}, p[1:0] == {p[2], 1'b0}};
      chk(tile_out == e, "R8 decoder one-hot", NB'(tile_out), NB'(e));
    end

    // R10: second-table column 0 left at zero
    v = {$urandom, $urandom};
    for (int r = 0; r < 8; r++) v[20+2*r] = 1'b0;
    load(v);
    sweep("R10 unused column");

    // Random images, with idle clocking in between (R4)
    for (int n = 0; n < 24; n++) begin
      v = {$urandom, $urandom};
      load(v);
      sweep("R6 R7 R8 R9 random image");
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        cfg_sin = 1'($urandom);
      end
      sweep("R4 idle clocks ignored");
    end

    // R1: reset in the middle of a partial load
    @(negedge clk);
    cfg_load = 1'b1;
    cfg_sin  = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    cfg_load = 1'b0;
    #1;
    chk(tile_out == 2'b00, "R1 outputs during reset", NB'(tile_out), '0);
    @(negedge clk);
    rst_n = 1'b1;
    cur = '0;
    sweep("R1 outputs after mid-load reset");
    load({$urandom, $urandom});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule